// File: doc/BRIEF.md
# Embedded-Sync 4:2:2 Byte-Stream Receiver

This block takes a single byte-wide video stream, one byte per pixel clock, in which luma and chroma samples are interleaved on the same bus. Line and field timing are not carried on separate wires. They travel inside the stream as four-byte timing codes. The block watches every byte for such a code. It decodes the code's last byte into three status flags: which field is current, whether the line lies in vertical blanking, and whether the code opens or closes a stretch of active video.

Bytes between an opening code and the next closing code are active data. They arrive as a repeating group of blue-difference chroma, first luma, red-difference chroma and second luma. The block gathers each group of four into one wide pixel-pair word and marks it with a one-clock valid strobe. Code bytes are never delivered as data. A run of active bytes cut short by a closing code is dropped.

Top module: `ycc_sync_demux`

## Requirements
- R1: While `rst_ni` is low, `fld_o`, `vblank_o`, `hflag_o` and `pair_vld_o` are 0. Without a new code, no pair is produced until an opening code has been seen.
- R2: A timing code is the byte run all-ones, all-zeros, all-zeros, then a status byte. On the clock edge that samples the status byte, `fld_o` takes status bit 6 (1 = second field, 0 = first field).
- R3: On that same edge, `vblank_o` takes status bit 5 (1 = vertical blanking).
- R4: On that same edge, `hflag_o` takes status bit 4. A value of 0 marks an opening code, after which the following bytes are active data. A value of 1 marks a closing code, after which bytes are ignored.
- R5: Status bits 7 and 3 to 0 have no effect on any output. An all-ones status byte decodes as field 1, blanking 1, closing 1.
- R6: The three flags hold their values unless a complete four-byte code arrives. An unfinished prefix such as all-ones, all-zeros, 0x77 leaves them unchanged.
- R7: Active bytes are packed in arrival order into `pair_o` as Cb in [31:24], Y0 in [23:16], Cr in [15:8] and Y1 in [7:0].
- R8: The byte position restarts at every code. The first byte after an opening code is always Cb, and an unfinished group before a closing code produces no pair.
- R9: `pair_vld_o` is high for exactly one clock. It goes high on the third clock edge after the edge that samples a group's Y1 byte, and only for groups made wholly of active data bytes.
- R10: An all-ones byte inside active video that is not followed by two all-zeros bytes is packed as ordinary data. A new all-ones byte restarts the code search, so all-ones, all-ones, zero, zero, status yields one data byte and one code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_i | input | BYTE_W (8) | Multiplexed stream byte, one per clock |
| pair_o | output | 4*BYTE_W (32) | Packed pixel pair {Cb, Y0, Cr, Y1} |
| pair_vld_o | output | 1 | One-clock strobe marking a new `pair_o` |
| fld_o | output | 1 | Field flag from the last code |
| vblank_o | output | 1 | Vertical blanking flag from the last code |
| hflag_o | output | 1 | Closing/opening flag from the last code |

## Verification
The bench targets all-ones bytes that sit inside active data. A receiver that acts too early would either treat them as a sync prefix and drop them, or slip the byte phase so that chroma and luma swap lanes. Runs of all-ones followed by all-ones, zero, zero check that the code search restarts. A design that resets its search to idle would miss that closing code and keep emitting pairs into blanking. Groups cut short by a closing code, followed by a fresh opening code, check that the phase restarts: a stale phase would show up as a shifted first pair. Status bytes with their protection bits set, including a status of all ones, check that only bits 6 to 4 are decoded.

// File: rtl/ycc_pkg.sv
`timescale 1ns/1ps
package ycc_pkg;
  // bytes in one timing code and in its fixed prefix
  localparam int unsigned CODE_LEN = 4;
  localparam int unsigned PRE_LEN  = CODE_LEN - 1;
  // samples per pixel pair: Cb, Y0, Cr, Y1
  localparam int unsigned LANES    = 4;
  // flag positions inside the status byte
  localparam int unsigned F_BIT    = 6;
  localparam int unsigned V_BIT    = 5;
  localparam int unsigned H_BIT    = 4;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_ONES,
    SC_ZERO1,
    SC_ZERO2
  } scan_e;
endpackage

// File: rtl/ycc_code_scan.sv
`timescale 1ns/1ps
module ycc_code_scan
  import ycc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              code_hit_o
);
  localparam logic [BYTE_W-1:0] ALL_ONES  = {BYTE_W{1'b1}};
  localparam logic [BYTE_W-1:0] ALL_ZEROS = {BYTE_W{1'b0}};

  scan_e st_q, st_d;

  always_comb begin
    st_d = SC_IDLE;
    if (st_q == SC_ZERO2) begin
      st_d = SC_IDLE;                        // current byte is the status byte
    end else if (byte_i == ALL_ONES) begin
      st_d = SC_ONES;                        // any all-ones restarts the search
    end else if (byte_i == ALL_ZEROS && st_q == SC_ONES) begin
      st_d = SC_ZERO1;
    end else if (byte_i == ALL_ZEROS && st_q == SC_ZERO1) begin
      st_d = SC_ZERO2;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SC_IDLE;
    else         st_q <= st_d;
  end

  assign code_hit_o = (st_q == SC_ZERO2);
endmodule

// File: rtl/ycc_pair_pack.sv
`timescale 1ns/1ps
module ycc_pair_pack
  import ycc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic                    live_i,
  input  logic                    kill_i,
  output logic [LANES*BYTE_W-1:0] pair_o,
  output logic                    pair_vld_o
);
  localparam int unsigned PH_W   = $clog2(LANES);
  localparam int unsigned PAIR_W = LANES * BYTE_W;

  // hold-back line: a byte is only committed once it can no longer be a code prefix
  logic [BYTE_W-1:0]  dly_q [PRE_LEN];
  logic [PRE_LEN-1:0] lv_q, lv_d;

  genvar g;
  generate
    for (g = 0; g < PRE_LEN; g++) begin : g_live
      if (g == 0) begin : g_head
        assign lv_d[g] = live_i;
      end else begin : g_tail
        assign lv_d[g] = lv_q[g-1] & ~kill_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    dly_q[0] <= byte_i;
    for (int i = 1; i < PRE_LEN; i++) dly_q[i] <= dly_q[i-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lv_q <= '0;
    else         lv_q <= lv_d;
  end

  logic [BYTE_W-1:0] head_byte;
  logic              take, last;
  logic [PH_W-1:0]   ph_q, ph_d;

  assign head_byte = dly_q[PRE_LEN-1];
  assign take      = lv_q[PRE_LEN-1] & ~kill_i;
  assign last      = take && (ph_q == PH_W'(LANES-1));

  always_comb begin
    ph_d = ph_q;
    if (kill_i)    ph_d = '0;
    else if (last) ph_d = '0;
    else if (take) ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_d;
  end

  // first three samples of a group wait here for the fourth
  logic [BYTE_W-1:0] lane_q [LANES-1];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < LANES-1; i++) begin
      if (take && ph_q == PH_W'(i)) lane_q[i] <= head_byte;
    end
  end

  logic [PAIR_W-1:0] pair_d, pair_q;
  logic              vld_q;

  always_comb begin
    pair_d = '0;
    for (int i = 0; i < LANES-1; i++) begin
      pair_d[PAIR_W-1-i*BYTE_W -: BYTE_W] = lane_q[i];
    end
    pair_d[BYTE_W-1:0] = head_byte;
  end

  always_ff @(posedge clk_i) begin
    if (last) pair_q <= pair_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= last;
  end

  assign pair_o     = pair_q;
  assign pair_vld_o = vld_q;
endmodule

// File: rtl/ycc_sync_demux.sv
`timescale 1ns/1ps
module ycc_sync_demux
  import ycc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [BYTE_W-1:0]       byte_i,
  output logic [LANES*BYTE_W-1:0] pair_o,
  output logic                    pair_vld_o,
  output logic                    fld_o,
  output logic                    vblank_o,
  output logic                    hflag_o
);
  logic code_hit;
  logic act_q, act_d;
  logic f_q, v_q, h_q;
  logic live;

  ycc_code_scan #(.BYTE_W(BYTE_W)) scan_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (byte_i),
    .code_hit_o (code_hit)
  );

  // active state changes only on a finished code, after its status byte
  assign act_d = code_hit ? ~byte_i[H_BIT] : act_q;
  assign live  = act_q & ~code_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      f_q   <= 1'b0;
      v_q   <= 1'b0;
      h_q   <= 1'b0;
    end else begin
      act_q <= act_d;
      if (code_hit) begin
        f_q <= byte_i[F_BIT];
        v_q <= byte_i[V_BIT];
        h_q <= byte_i[H_BIT];
      end
    end
  end

  ycc_pair_pack #(.BYTE_W(BYTE_W)) pack_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (byte_i),
    .live_i     (live),
    .kill_i     (code_hit),
    .pair_o     (pair_o),
    .pair_vld_o (pair_vld_o)
  );

  assign fld_o    = f_q;
  assign vblank_o = v_q;
  assign hflag_o  = h_q;
endmodule

// File: rtl/ycc_sync_demux_chk.sv
`timescale 1ns/1ps
module ycc_sync_demux_chk
  import ycc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [BYTE_W-1:0] byte_i,
  input logic              code_hit,
  input logic              fld_o,
  input logic              vblank_o,
  input logic              hflag_o,
  input logic              pair_vld_o
);
  // R2
  code_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_hit |-> ($past(byte_i, 3) == {BYTE_W{1'b1}} &&
                  $past(byte_i, 2) == {BYTE_W{1'b0}} &&
                  $past(byte_i, 1) == {BYTE_W{1'b0}}));

  // R2
  fld_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(code_hit) |-> fld_o == $past(byte_i[F_BIT]));

  // R3
  vblank_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(code_hit) |-> vblank_o == $past(byte_i[V_BIT]));

  // R4
  hflag_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(code_hit) |-> hflag_o == $past(byte_i[H_BIT]));

  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(code_hit) |-> $stable({fld_o, vblank_o, hflag_o}));

  // R9
  vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |=> !pair_vld_o);

  // R9
  vld_not_after_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(code_hit) |-> !pair_vld_o);
endmodule

bind ycc_sync_demux ycc_sync_demux_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_i     (byte_i),
  .code_hit   (code_hit),
  .fld_o      (fld_o),
  .vblank_o   (vblank_o),
  .hflag_o    (hflag_o),
  .pair_vld_o (pair_vld_o)
);

// File: tb/ycc_sync_demux_tb_top.sv
`timescale 1ns/1ps
module ycc_sync_demux_tb_top;
  localparam int N  = 3000;
  localparam int NT = N + 8;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  byte_i;
  logic [31:0] pair_o;
  logic        pair_vld_o, fld_o, vblank_o, hflag_o;

  always #4 clk_i = ~clk_i;

  ycc_sync_demux #(.BYTE_W(8)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_i     (byte_i),
    .pair_o     (pair_o),
    .pair_vld_o (pair_vld_o),
    .fld_o      (fld_o),
    .vblank_o   (vblank_o),
    .hflag_o    (hflag_o)
  );

  logic [7:0]  stim     [NT];
  bit          code_any [NT];
  bit          code_st  [NT];
  logic        exp_f    [NT];
  logic        exp_v    [NT];
  logic        exp_h    [NT];
  logic        exp_vld  [NT];
  logic [31:0] exp_pair [NT];
  bit          hp_en    [NT];
  logic [31:0] hp_val   [NT];
  string       hp_tag   [NT];
  bit          hf_en    [NT];
  logic [2:0]  hf_val   [NT];
  string       hf_tag   [NT];

  int wp = 0;
  int n_chk = 0;
  int n_err = 0;

  function automatic void put(logic [7:0] b);
    stim[wp] = b;
    wp++;
  endfunction

  function automatic void put_code(logic [7:0] s);
    put(8'hFF); put(8'h00); put(8'h00); put(s);
  endfunction

  function automatic logic [7:0] stat(bit f, bit v, bit h, logic [7:0] junk);
    return (junk & 8'h8F) | {1'b0, f, v, h, 4'b0000};
  endfunction

  // k is the index of the group's last byte; its pair shows three edges later
  function automatic void want_pair(int k, logic [31:0] p, string t);
    hp_en[k+3]  = 1'b1;
    hp_val[k+3] = p;
    hp_tag[k+3] = t;
  endfunction

  function automatic void want_flags(logic [2:0] fvh, string t);
    hf_en[wp-1]  = 1'b1;
    hf_val[wp-1] = fvh;
    hf_tag[wp-1] = t;
  endfunction

  // reference model straight from the requirements, with full lookahead
  function automatic void build_model();
    int i;
    bit act, f, v, h;
    int ph;
    logic [7:0] grp [4];
    for (int k = 0; k < NT; k++) begin
      code_any[k] = 1'b0; code_st[k] = 1'b0; exp_vld[k] = 1'b0; exp_pair[k] = '0;
    end
    i = 0;
    while (i + 3 < NT) begin
      if (stim[i] == 8'hFF && stim[i+1] == 8'h00 && stim[i+2] == 8'h00) begin
        for (int k = 0; k < 4; k++) code_any[i+k] = 1'b1;
        code_st[i+3] = 1'b1;
        i += 4;
      end else begin
        i++;
      end
    end
    act = 0; f = 0; v = 0; h = 0; ph = 0;
    for (int k = 0; k < NT; k++) begin
      if (code_st[k]) begin
        f = stim[k][6]; v = stim[k][5]; h = stim[k][4];
        act = !h; ph = 0;
      end else if (!code_any[k] && act) begin
        grp[ph] = stim[k];
        ph++;
        if (ph == 4) begin
          if (k + 3 < NT) begin
            exp_vld[k+3]  = 1'b1;
            exp_pair[k+3] = {grp[0], grp[1], grp[2], grp[3]};
          end
          ph = 0;
        end
      end
      exp_f[k] = f; exp_v[k] = v; exp_h[k] = h;
    end
  endfunction

  function automatic void check(bit ok, string req, string what,
                                logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endfunction

  function automatic void check_index(int n);
    check(fld_o === exp_f[n], "R2", "field flag", 32'(fld_o), 32'(exp_f[n]));
    check(vblank_o === exp_v[n], "R3", "vblank flag", 32'(vblank_o), 32'(exp_v[n]));
    check(hflag_o === exp_h[n], "R4", "h flag", 32'(hflag_o), 32'(exp_h[n]));
    check(pair_vld_o === exp_vld[n], "R9", "pair valid", 32'(pair_vld_o), 32'(exp_vld[n]));
    if (exp_vld[n])
      check(pair_o === exp_pair[n], "R7", "pair data", pair_o, exp_pair[n]);
    if (hp_en[n])
      check(pair_vld_o === 1'b1 && pair_o === hp_val[n], hp_tag[n], "directed pair",
            pair_o, hp_val[n]);
    if (hf_en[n])
      check({fld_o, vblank_o, hflag_o} === hf_val[n], hf_tag[n], "directed flags",
            32'({fld_o, vblank_o, hflag_o}), 32'(hf_val[n]));
  endfunction

  function automatic void build_stim();
    for (int k = 0; k < NT; k++) begin hp_en[k] = 1'b0; hf_en[k] = 1'b0; end
    repeat (4) put(8'h10);
    put_code(stat(1, 1, 1, 8'hFF));           // R5: all-ones status
    want_flags(3'b111, "R5");
    put(8'hFF); put(8'h00); put(8'h77); put(8'hFF); put(8'h55);
    want_flags(3'b111, "R6");                 // unfinished prefixes change nothing
    put_code(stat(0, 0, 0, 8'h0A));
    want_flags(3'b000, "R5");
    put(8'h11); put(8'h22); put(8'h33); put(8'h44); want_pair(wp-1, 32'h11223344, "R7");
    put(8'h55); put(8'h66); put(8'h77); put(8'h88); want_pair(wp-1, 32'h55667788, "R7");
    put_code(stat(0, 0, 1, 8'h85));
    want_flags(3'b001, "R4");
    put(8'h10); put(8'h80);
    put_code(stat(1, 1, 0, 8'h00));
    put(8'hA1); put(8'hA2); put(8'hA3); put(8'hA4); put(8'hA5); put(8'hA6);
    put_code(stat(1, 1, 1, 8'h00));
    put_code(stat(1, 1, 0, 8'h00));
    put(8'hB1); put(8'hB2); put(8'hB3); put(8'hB4); want_pair(wp-1, 32'hB1B2B3B4, "R8");
    put_code(stat(1, 1, 1, 8'h00));
    put_code(stat(0, 0, 0, 8'h00));
    put(8'hFF); put(8'h01); put(8'h02); put(8'h03); want_pair(wp-1, 32'hFF010203, "R10");
    put(8'hFF); put(8'h00); put(8'h05); put(8'h06); want_pair(wp-1, 32'hFF000506, "R10");
    put(8'hC1); put(8'hC2); put(8'hC3); put(8'hFF); want_pair(wp-1, 32'hC1C2C3FF, "R10");
    put_code(stat(0, 1, 1, 8'h00));
    want_flags(3'b011, "R10");
    // constrained random lines
    while (wp < N - 250) begin
      bit f, v;
      int len;
      f = 1'($urandom_range(0, 1));
      v = 1'($urandom_range(0, 1));
      repeat ($urandom_range(0, 6)) put(8'($urandom_range(0, 254)));
      put_code(stat(f, v, 0, 8'($urandom)));
      len = $urandom_range(0, 40);
      for (int k = 0; k < len; k++) begin
        if ($urandom_range(0, 15) == 0) put(8'hFF);
        else put(8'($urandom_range(0, 255)));
        if ($urandom_range(0, 20) == 0) begin
          put(8'hFF); put(8'h00); put(8'($urandom_range(1, 255)));
        end
      end
      put_code(stat(f, v, 1, 8'($urandom)));
    end
    while (wp < NT) put(8'h10);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0422));
    build_stim();
    build_model();
    rst_ni = 1'b0;
    byte_i = 8'h10;
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check(fld_o === 1'b0 && vblank_o === 1'b0 && hflag_o === 1'b0, "R1", "reset flags",
          32'({fld_o, vblank_o, hflag_o}), 32'h0);
    check(pair_vld_o === 1'b0, "R1", "reset valid", 32'(pair_vld_o), 32'h0);
    rst_ni = 1'b1;
    for (int n = 0; n < NT; n++) begin
      byte_i = stim[n];
      @(negedge clk_i);
      check_index(n);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule